// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows a processor's power state from three active-low control inputs: stop-clock, sleep and deep-sleep. It drives clock enables for three domains (core, bus interface, interrupt controller). It also drives a request to issue a stop-grant acknowledge bus transaction, and two flags that say whether snoops and interrupts may be serviced at the moment. The power states are running, stop-grant, sleep and deep sleep. Which input is honoured depends on the state the block is in.

All three control inputs arrive asynchronously. Each one passes through its own two-flop synchronizer, and a transition is taken only on a synchronized level. A synchronous, active-high reset returns the block to the running state.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `pwr_state` is 0 (running). All three clock enables and both service flags are 1, and `ack_req` is 0.
- R2: In running, a low `stpclk_n` moves the block to stop-grant (`pwr_state` = 1). There the core clock enable is 0, the bus and interrupt-controller clock enables are 1, and the snoop and interrupt flags are 1.
- R3: The move from running to stop-grant raises `ack_req`, and only that transition raises it. `ack_req` stays high until `ack_grant` is seen high at a rising edge, and goes low at that edge.
- R4: In stop-grant, a high `stpclk_n` returns the block to running, with all clock enables and both flags at 1.
- R5: A low `slp_n` acts only in stop-grant, where it moves the block to sleep (`pwr_state` = 2). In sleep, all three clock enables and both flags are 0. A low `slp_n` seen in running leaves the state unchanged.
- R6: In sleep, a high `slp_n` returns the block to stop-grant, and the bus and interrupt-controller clock enables come back on. This takes priority over a deep-sleep request seen in the same cycle.
- R7: In sleep, a low `dpslp_n` moves the block to deep sleep (`pwr_state` = 3), with all enables and flags at 0.
- R8: In deep sleep, a high `dpslp_n` returns the block to sleep.
- R9: The following input changes leave the state unchanged: `stpclk_n` in sleep, `slp_n` in deep sleep, and `dpslp_n` in running or stop-grant.
- R10: An input level set up before rising edge k has no visible effect after edges k and k+1. The outputs change at edge k+2.
- R11: The bus-interface clock enable is 1 in every cycle the block spends in running or stop-grant, whatever `stpclk_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| stpclk_n | input | 1 | Stop-clock request, active low, asynchronous |
| slp_n | input | 1 | Sleep request, active low, asynchronous |
| dpslp_n | input | 1 | Deep-sleep request, active low, asynchronous |
| ack_grant | input | 1 | Bus accepts the pending acknowledge request |
| core_clk_en | output | 1 | Core clock domain enable |
| bus_clk_en | output | 1 | Bus-interface clock domain enable |
| irq_clk_en | output | 1 | Interrupt-controller clock domain enable |
| ack_req | output | 1 | Request to issue the stop-grant acknowledge transaction |
| snoop_en | output | 1 | Snoops may be serviced |
| intr_en | output | 1 | Interrupts may be serviced |
| pwr_state | output | 2 | Current state: 0 running, 1 stop-grant, 2 sleep, 3 deep sleep |

## Verification
The bench asserts sleep and deep-sleep in states where they must be ignored. A controller that skipped the state test would fall from running straight into sleep, or into deep sleep from stop-grant. It changes stop-clock and sleep while in sleep and deep sleep, which catches a design that woke up on the wrong input. It checks the exact cycle each change takes effect, one edge early and on time, so a missing or extra synchronizer stage is seen. It holds the acknowledge request open for many cycles without a grant and returns to stop-grant from sleep, so a design that dropped the request early or raised it again would be caught.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STPGT = 2'd1,
    ST_SLEEP = 2'd2,
    ST_DEEP  = 2'd3
  } pwr_state_t;

  typedef struct packed {
    logic core;
    logic bus;
    logic irq;
    logic snoop;
    logic intr;
  } pwr_en_t;

  function automatic pwr_en_t decode_en(pwr_state_t s);
    pwr_en_t e;
    case (s)
      ST_RUN:   e = '{core: 1'b1, bus: 1'b1, irq: 1'b1, snoop: 1'b1, intr: 1'b1};
      ST_STPGT: e = '{core: 1'b0, bus: 1'b1, irq: 1'b1, snoop: 1'b1, intr: 1'b1};
      default:  e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  // Idle level of the active-low inputs is 1
  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '1;
    else     chain[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= '1;
      else     chain[g] <= chain[g-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stp_req,
  input  logic       slp_req,
  input  logic       dps_req,
  output pwr_state_t state_q,
  output pwr_state_t state_d
);
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:   if (stp_req)  state_d = ST_STPGT;
      ST_STPGT: begin
        if (!stp_req)     state_d = ST_RUN;
        else if (slp_req) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!slp_req)     state_d = ST_STPGT;
        else if (dps_req) state_d = ST_DEEP;
      end
      ST_DEEP:  if (!dps_req) state_d = ST_SLEEP;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  // R2: running leaves only toward stop-grant
  assert_run_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |=> (state_q == ST_RUN || state_q == ST_STPGT));
  // R5: sleep is reached only from stop-grant or deep sleep
  assert_sleep_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && !$past(rst)) |->
      ($past(state_q) == ST_STPGT || $past(state_q) == ST_SLEEP || $past(state_q) == ST_DEEP));
  // R7: deep sleep is reached only from sleep
  assert_deep_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEEP && !$past(rst)) |-> ($past(state_q) == ST_SLEEP || $past(state_q) == ST_DEEP));
  // R8: deep sleep leaves only toward sleep
  assert_deep_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEEP) |=> (state_q == ST_DEEP || state_q == ST_SLEEP));
endmodule

// File: rtl/pwr_ack.sv
module pwr_ack (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic grant_i,
  output logic req_o
);
  always_ff @(posedge clk) begin
    if (rst)          req_o <= 1'b0;
    else if (set_i)   req_o <= 1'b1;
    else if (grant_i) req_o <= 1'b0;
  end

  // R3: the request is withdrawn only after a grant
  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (req_o && !grant_i) |=> req_o);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stpclk_n,
  input  logic       slp_n,
  input  logic       dpslp_n,
  input  logic       ack_grant,
  output logic       core_clk_en,
  output logic       bus_clk_en,
  output logic       irq_clk_en,
  output logic       ack_req,
  output logic       snoop_en,
  output logic       intr_en,
  output logic [1:0] pwr_state
);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] pins_n, synced_n;
  pwr_state_t        st_q, st_d;
  pwr_en_t           en_q;

  assign pins_n = {dpslp_n, slp_n, stpclk_n};

  pwr_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pins_n), .sync_o(synced_n)
  );

  pwr_fsm u_fsm (
    .clk(clk), .rst(rst),
    .stp_req(~synced_n[0]), .slp_req(~synced_n[1]), .dps_req(~synced_n[2]),
    .state_q(st_q), .state_d(st_d)
  );

  pwr_ack u_ack (
    .clk(clk), .rst(rst),
    .set_i(st_q == ST_RUN && st_d == ST_STPGT),
    .grant_i(ack_grant), .req_o(ack_req)
  );

  always_ff @(posedge clk) begin
    if (rst) en_q <= decode_en(ST_RUN);
    else     en_q <= decode_en(st_d);
  end

  assign core_clk_en = en_q.core;
  assign bus_clk_en  = en_q.bus;
  assign irq_clk_en  = en_q.irq;
  assign snoop_en    = en_q.snoop;
  assign intr_en     = en_q.intr;
  assign pwr_state   = st_q;

  // R11: bus clock stays on while running or in stop-grant
  assert_bus_on_R11: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd0 || pwr_state == 2'd1) |-> bus_clk_en);
  // R5: servicing snoops implies the bus domain is clocked
  assert_snoop_needs_bus_R5: assert property (@(posedge clk) disable iff (rst)
    snoop_en |-> (bus_clk_en && irq_clk_en));
  // R3: a new request appears only on entry to stop-grant
  assert_ack_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_req) |-> (pwr_state == 2'd1 && $past(pwr_state) == 2'd0));
endmodule

// File: tb/pwr_state_ctrl_bench.sv
`timescale 1ns/100ps
module pwr_state_ctrl_bench;
  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stpclk_n = 1'b1, slp_n = 1'b1, dpslp_n = 1'b1, ack_grant = 1'b0;
  logic core_clk_en, bus_clk_en, irq_clk_en, ack_req, snoop_en, intr_en;
  logic [1:0] pwr_state;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic tick = 1'b0;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  pwr_state_ctrl u_pwr_state_ctrl (
    .clk(clk), .rst(rst), .stpclk_n(stpclk_n), .slp_n(slp_n), .dpslp_n(dpslp_n),
    .ack_grant(ack_grant), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
    .irq_clk_en(irq_clk_en), .ack_req(ack_req), .snoop_en(snoop_en),
    .intr_en(intr_en), .pwr_state(pwr_state)
  );

  // expected vector: {state[1:0], core, bus, irq, snoop, intr, ack}
  function automatic logic [7:0] expv(int st, logic ack);
    case (st)
      0: return {2'd0, 5'b11111, ack};
      1: return {2'd1, 5'b01111, ack};
      2: return {2'd2, 5'b00000, ack};
      default: return {2'd3, 5'b00000, ack};
    endcase
  endfunction

  // monitor: pops the oldest expectation and compares with the outputs
  always @(posedge tick) begin
    sb_item_t it;
    logic [7:0] act;
    act = {pwr_state, core_clk_en, bus_clk_en, irq_clk_en, snoop_en, intr_en, ack_req};
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  task automatic check_now(int st, logic ack, string tag);
    sb_item_t it;
    it.exp = expv(st, ack);
    it.tag = tag;
    sb_q.push_back(it);
    tick = 1'b1;
    #0.1 tick = 1'b0;
  endtask

  // drive at a falling edge, check still old after two edges, new after the third (R10)
  task automatic apply(int which, logic lvl, int old_st, logic old_ack,
                       int new_st, logic new_ack, string tag);
    @(negedge clk);
    case (which)
      0: stpclk_n = lvl;
      1: slp_n    = lvl;
      default: dpslp_n = lvl;
    endcase
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_now(old_st, old_ack, {"R10 ", tag, " early"});
    @(posedge clk);
    @(negedge clk);
    check_now(new_st, new_ack, tag);
  endtask

  task automatic idle(int n, int st, logic ack, string tag);
    repeat (n) @(negedge clk);
    check_now(st, ack, tag);
  endtask

  task automatic grant_once(int st);
    @(negedge clk);
    ack_grant = 1'b1;
    @(negedge clk);
    ack_grant = 1'b0;
    check_now(st, 1'b0, "R3 cleared by grant");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_now(0, 1'b0, "R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check_now(0, 1'b0, "R1 after reset");

    apply(1, 1'b0, 0, 1'b0, 0, 1'b0, "R5 sleep ignored in running");
    apply(1, 1'b1, 0, 1'b0, 0, 1'b0, "R5 sleep release in running");
    apply(2, 1'b0, 0, 1'b0, 0, 1'b0, "R9 deep ignored in running");
    apply(2, 1'b1, 0, 1'b0, 0, 1'b0, "R9 deep release in running");

    apply(0, 1'b0, 0, 1'b0, 1, 1'b1, "R2 R11 enter stop-grant");
    idle(8, 1, 1'b1, "R3 request held without grant");
    grant_once(1);
    idle(5, 1, 1'b0, "R3 no second request");

    apply(2, 1'b0, 1, 1'b0, 1, 1'b0, "R9 deep ignored in stop-grant");
    apply(2, 1'b1, 1, 1'b0, 1, 1'b0, "R9 deep release in stop-grant");

    apply(1, 1'b0, 1, 1'b0, 2, 1'b0, "R5 enter sleep");
    apply(0, 1'b1, 2, 1'b0, 2, 1'b0, "R9 stop-clock ignored in sleep");
    apply(0, 1'b0, 2, 1'b0, 2, 1'b0, "R9 stop-clock back low in sleep");

    apply(2, 1'b0, 2, 1'b0, 3, 1'b0, "R7 enter deep sleep");
    apply(1, 1'b1, 3, 1'b0, 3, 1'b0, "R9 sleep release ignored in deep");
    apply(1, 1'b0, 3, 1'b0, 3, 1'b0, "R9 sleep low again in deep");
    apply(2, 1'b1, 3, 1'b0, 2, 1'b0, "R8 deep release to sleep");

    apply(1, 1'b1, 2, 1'b0, 1, 1'b0, "R6 sleep release to stop-grant");
    apply(0, 1'b1, 1, 1'b0, 0, 1'b0, "R4 back to running");

    apply(0, 1'b0, 0, 1'b0, 1, 1'b1, "R3 second entry raises request");
    grant_once(1);

    // R6 priority: sleep released and deep asserted together in sleep
    apply(1, 1'b0, 1, 1'b0, 2, 1'b0, "R5 sleep again");
    @(negedge clk);
    slp_n = 1'b1;
    dpslp_n = 1'b0;
    idle(4, 1, 1'b0, "R6 release wins over deep");
    dpslp_n = 1'b1;

    apply(1, 1'b0, 1, 1'b0, 2, 1'b0, "R5 sleep before reset");
    @(negedge clk);
    rst = 1'b1;
    stpclk_n = 1'b1;
    slp_n = 1'b1;
    @(negedge clk);
    check_now(0, 1'b0, "R1 reset from sleep");
    rst = 1'b0;
    idle(4, 0, 1'b0, "R1 stays running");

    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule